// File: doc/BRIEF.md
# Sleep and Wake Sequencer

This block decides when a small processor core may stop its clocks and how it comes back. Software arms sleep by setting an enable bit and a two-bit mode field in a local control register. The instruction decoder then raises a one-cycle sleep strobe. If the enable bit is set, the core stalls and the clock domains are gated according to the mode. If the bit is clear, the strobe does nothing.

While asleep, the block watches five wake sources that have already been masked: an external level interrupt, the watchdog, a pin-change event, a timer event and an ADC-done event. Which of them may end sleep depends on the mode. In the two deep modes the oscillator first needs a start-up delay. This delay is taken from an input for Power-down and is fixed for Standby. After the start-up delay, every mode holds the core stalled for four more cycles. Then a one-cycle take-interrupt pulse hands control to interrupt service. A warm reset request ends any sleep at once and asks the core to restart from its reset vector.

The block has no storage for the core's data. Register file and memory contents are untouched because only clock enables and a stall are driven.

Top module: `slpwk_ctrl`

## Requirements
- R1: After reset, all five clock enables are 1, cpu_stall, take_irq and restart_vec are 0, and the control register holds enable=0, mode=00.
- R2: A sleep_op strobe while the enable bit is 0 has no effect: the clock enables stay all on and cpu_stall stays 0.
- R3: A sleep_op strobe with the enable bit set, while the core is active, makes cpu_stall 1 from the next clock edge. The enables {cpu,flash,io,adc,osc} then read 00111 for mode 00 (Idle), 00011 for mode 01 (ADC quiet), 00000 for mode 10 (Power-down) and 00001 for mode 11 (Standby).
- R4: In modes 00 and 01, any of the five wake sources ends sleep. In modes 10 and 11, only wk_level, wk_wdt and wk_pin do; wk_timer and wk_adc leave the core asleep with unchanged enables.
- R5: Start-up time is 0 cycles in modes 00 and 01, 6 cycles in mode 11, and max(pd_startup,1) cycles in mode 10. The edge that samples the wake is edge 1; take_irq is 1 after edge start-up+5. During start-up only the osc enable is 1. The four halt cycles that follow have all enables at 1 and cpu_stall at 1.
- R6: take_irq is high for exactly one cycle, with cpu_stall 0 in that cycle. The core is then active: cpu_stall 0 and all enables at 1.
- R7: In modes 10 and 11, a wake caused only by wk_level is accepted only if wk_level is still 1 when the start-up delay ends. Otherwise the block returns to sleep with the mode's enables and no take_irq.
- R8: warm_rst in any state gives, after the next edge, restart_vec=1 for one cycle, cpu_stall=0, take_irq=0 and all enables on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running clock of the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_se | input | 1 | Sleep-enable value written on cfg_wr |
| cfg_mode | input | 2 | Mode value written on cfg_wr (00 Idle, 01 ADC quiet, 10 Power-down, 11 Standby) |
| sleep_op | input | 1 | One-cycle strobe from the decoder for a sleep instruction |
| pd_startup | input | DLY_W | Start-up delay in cycles for Power-down |
| wk_level | input | 1 | Masked external level interrupt |
| wk_wdt | input | 1 | Masked watchdog interrupt |
| wk_pin | input | 1 | Masked pin-change interrupt |
| wk_timer | input | 1 | Masked timer interrupt |
| wk_adc | input | 1 | Masked ADC-complete interrupt |
| warm_rst | input | 1 | Synchronous reset request that restarts the core at its reset vector |
| clk_cpu_en | output | 1 | Enable for the CPU clock domain |
| clk_flash_en | output | 1 | Enable for the program memory clock domain |
| clk_io_en | output | 1 | Enable for the I/O clock domain |
| clk_adc_en | output | 1 | Enable for the ADC clock domain |
| clk_osc_en | output | 1 | Enable for the oscillator and asynchronous domain |
| cpu_stall | output | 1 | Holds the core while sleeping or waking |
| take_irq | output | 1 | One-cycle pulse: start interrupt service |
| restart_vec | output | 1 | One-cycle pulse: restart from the reset vector |

## Verification
The bench measures the wake latency edge by edge in every mode, with random Power-down delays that include zero. A design that miscounted the start-up or the four halt cycles would show take_irq a cycle early or late. It drives timer and ADC events into the deep modes and a short level pulse that ends before start-up is over. A design with a wrong source filter, or one that skipped the level re-check, would raise take_irq where it must stay asleep. It also strobes sleep with the enable bit clear and raises warm_rst in the middle of start-up. A wrong design would stall the core, or would let an interrupt pulse escape when a restart was requested.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_STARTUP = 3'd2,
    ST_HALT4   = 3'd3,
    ST_RUN_ISR = 3'd4
  } slp_state_e;

  typedef enum logic [1:0] {
    MD_IDLE  = 2'b00,
    MD_QUIET = 2'b01,
    MD_PWRDN = 2'b10,
    MD_STBY  = 2'b11
  } slp_mode_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic osc;
  } clk_gate_t;

  // wake source positions in the source vector
  localparam int SRC_LEVEL = 0;
  localparam int SRC_WDT   = 1;
  localparam int SRC_PIN   = 2;
  localparam int SRC_TIMER = 3;
  localparam int SRC_ADC   = 4;
  localparam int N_SRC     = 5;

  // sources allowed to end a deep (oscillator-off) sleep
  localparam logic [N_SRC-1:0] DEEP_WAKE_MASK = 5'b00111;

  function automatic logic is_deep(slp_mode_e md);
    return md[1];
  endfunction

  function automatic clk_gate_t gate_for(slp_state_e st, slp_mode_e md);
    clk_gate_t g;
    g = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};
    case (st)
      ST_SLEEP: begin
        g.cpu   = 1'b0;
        g.flash = 1'b0;
        case (md)
          MD_IDLE:  g = '{cpu: 1'b0, flash: 1'b0, io: 1'b1, adc: 1'b1, osc: 1'b1};
          MD_QUIET: g = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b1, osc: 1'b1};
          MD_PWRDN: g = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b0};
          default:  g = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
        endcase
      end
      ST_STARTUP: g = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
      default:    g = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/slpwk_rst_sync.sv
module slpwk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/slpwk_wake_qual.sv
module slpwk_wake_qual
  import slpwk_pkg::*;
(
  input  slp_mode_e         mode,
  input  logic [N_SRC-1:0]  src,
  output logic              wake,
  output logic              lvl_only
);

  logic [N_SRC-1:0] hit;
  logic             light;

  assign light = ~is_deep(mode);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = src[i] & (light | DEEP_WAKE_MASK[i]);
  end

  assign wake = |hit;

  // the level source alone caused the wake (no edge-type source alongside)
  always_comb begin
    logic [N_SRC-1:0] others;
    others           = hit;
    others[SRC_LEVEL] = 1'b0;
    lvl_only         = hit[SRC_LEVEL] & ~|others;
  end

endmodule

// File: rtl/slpwk_dly_cnt.sv
module slpwk_dly_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/slpwk_gate_reg.sv
module slpwk_gate_reg
  import slpwk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  slp_state_e st_nx,
  input  slp_mode_e  md_nx,
  output clk_gate_t  gate_q
);

  clk_gate_t gate_d;

  assign gate_d = gate_for(st_nx, md_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};
    end else begin
      gate_q <= gate_d;
    end
  end

endmodule

// File: rtl/slpwk_ctrl.sv
module slpwk_ctrl
  import slpwk_pkg::*;
#(
  parameter int DLY_W    = 8,
  parameter int SB_DELAY = 6,
  parameter int HALT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_se,
  input  logic [1:0]       cfg_mode,
  input  logic             sleep_op,
  input  logic [DLY_W-1:0] pd_startup,
  input  logic             wk_level,
  input  logic             wk_wdt,
  input  logic             wk_pin,
  input  logic             wk_timer,
  input  logic             wk_adc,
  input  logic             warm_rst,
  output logic             clk_cpu_en,
  output logic             clk_flash_en,
  output logic             clk_io_en,
  output logic             clk_adc_en,
  output logic             clk_osc_en,
  output logic             cpu_stall,
  output logic             take_irq,
  output logic             restart_vec
);

  localparam logic [DLY_W-1:0] SB_LOAD   = DLY_W'(SB_DELAY - 1);
  localparam logic [DLY_W-1:0] HALT_LOAD = DLY_W'(HALT_CYC - 1);

  logic rst_ns;

  slpwk_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_ns)
  );

  // control register
  logic      cfg_se_q, cfg_se_d;
  slp_mode_e cfg_mode_q, cfg_mode_d;

  always_comb begin
    cfg_se_d   = cfg_se;
    cfg_mode_d = slp_mode_e'(cfg_mode);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cfg_se_q   <= 1'b0;
      cfg_mode_q <= MD_IDLE;
    end else if (cfg_wr) begin
      cfg_se_q   <= cfg_se_d;
      cfg_mode_q <= cfg_mode_d;
    end
  end

  // wake qualification against the latched sleep mode
  slp_mode_e        mode_q, mode_d;
  logic [N_SRC-1:0] wk_vec;
  logic             wake, lvl_only;

  always_comb begin
    wk_vec            = '0;
    wk_vec[SRC_LEVEL] = wk_level;
    wk_vec[SRC_WDT]   = wk_wdt;
    wk_vec[SRC_PIN]   = wk_pin;
    wk_vec[SRC_TIMER] = wk_timer;
    wk_vec[SRC_ADC]   = wk_adc;
  end

  slpwk_wake_qual i_wake_qual (
    .mode     (mode_q),
    .src      (wk_vec),
    .wake     (wake),
    .lvl_only (lvl_only)
  );

  // shared start-up / halt counter
  logic             cnt_load, cnt_dec, cnt_zero;
  logic [DLY_W-1:0] cnt_val;
  logic [DLY_W-1:0] pd_load;

  assign pd_load = (pd_startup == '0) ? '0 : pd_startup - 1'b1;

  slpwk_dly_cnt #(.W(DLY_W)) i_dly_cnt (
    .clk      (clk),
    .rst_n    (rst_ns),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .zero     (cnt_zero)
  );

  // sequencer
  slp_state_e state_q, state_d;
  logic       lvl_q, lvl_d, lvl_en;
  logic       mode_en;

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    mode_en  = 1'b0;
    lvl_d    = lvl_q;
    lvl_en   = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    case (state_q)
      ST_ACTIVE: begin
        if (sleep_op && cfg_se_q) begin
          state_d = ST_SLEEP;
          mode_d  = cfg_mode_q;
          mode_en = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wake) begin
          lvl_en = 1'b1;
          lvl_d  = lvl_only & is_deep(mode_q);
          cnt_load = 1'b1;
          if (is_deep(mode_q)) begin
            state_d = ST_STARTUP;
            cnt_val = (mode_q == MD_STBY) ? SB_LOAD : pd_load;
          end else begin
            state_d = ST_HALT4;
            cnt_val = HALT_LOAD;
          end
        end
      end
      ST_STARTUP: begin
        if (cnt_zero) begin
          if (lvl_q && !wk_level) begin
            state_d = ST_SLEEP;
          end else begin
            state_d  = ST_HALT4;
            cnt_load = 1'b1;
            cnt_val  = HALT_LOAD;
          end
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_HALT4: begin
        if (cnt_zero) begin
          state_d = ST_RUN_ISR;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_RUN_ISR: state_d = ST_ACTIVE;
      default:    state_d = ST_ACTIVE;
    endcase
    if (warm_rst) begin
      state_d  = ST_ACTIVE;
      cnt_load = 1'b0;
      cnt_dec  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_ACTIVE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      mode_q <= MD_IDLE;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      lvl_q <= 1'b0;
    end else if (lvl_en) begin
      lvl_q <= lvl_d;
    end
  end

  // registered outputs, decoded from the next state
  clk_gate_t gate_q;
  logic      stall_d, take_d;
  logic      stall_q, take_q, restart_q;

  slpwk_gate_reg i_gate_reg (
    .clk    (clk),
    .rst_n  (rst_ns),
    .st_nx  (state_d),
    .md_nx  (mode_en ? mode_d : mode_q),
    .gate_q (gate_q)
  );

  always_comb begin
    stall_d = (state_d == ST_SLEEP) || (state_d == ST_STARTUP) || (state_d == ST_HALT4);
    take_d  = (state_d == ST_RUN_ISR);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      stall_q   <= 1'b0;
      take_q    <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      stall_q   <= stall_d;
      take_q    <= take_d;
      restart_q <= warm_rst;
    end
  end

  assign clk_cpu_en   = gate_q.cpu;
  assign clk_flash_en = gate_q.flash;
  assign clk_io_en    = gate_q.io;
  assign clk_adc_en   = gate_q.adc;
  assign clk_osc_en   = gate_q.osc;
  assign cpu_stall    = stall_q;
  assign take_irq     = take_q;
  assign restart_vec  = restart_q;

endmodule

// File: rtl/slpwk_chk.sv
module slpwk_chk
  import slpwk_pkg::*;
(
  input logic       clk,
  input logic       rst_ns,
  input slp_state_e state_q,
  input slp_mode_e  mode_q,
  input logic       cfg_se_q,
  input logic       sleep_op,
  input logic       warm_rst,
  input logic       wk_level,
  input logic       wk_wdt,
  input logic       wk_pin,
  input logic       clk_cpu_en,
  input logic       clk_flash_en,
  input logic       clk_io_en,
  input logic       clk_adc_en,
  input logic       clk_osc_en,
  input logic       cpu_stall,
  input logic       take_irq,
  input logic       restart_vec
);

  p_active_clocks_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    !cpu_stall |-> (clk_cpu_en && clk_flash_en && clk_io_en && clk_adc_en && clk_osc_en));

  p_noop_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_ACTIVE && sleep_op && !cfg_se_q && !warm_rst) |=> !cpu_stall);

  p_enter_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_ACTIVE && sleep_op && cfg_se_q && !warm_rst) |=> (cpu_stall && !clk_cpu_en));

  p_deep_filter_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_SLEEP && mode_q[1] && !wk_level && !wk_wdt && !wk_pin && !warm_rst)
      |=> (state_q == ST_SLEEP));

  p_take_after_halt_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    take_irq |-> ($past(state_q) == ST_HALT4));

  p_take_pulse_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    take_irq |=> !take_irq);

  p_take_nostall_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    take_irq |-> !cpu_stall);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    warm_rst |=> (restart_vec && !cpu_stall && !take_irq));

endmodule

bind slpwk_ctrl slpwk_chk i_slpwk_chk (
  .clk          (clk),
  .rst_ns       (rst_ns),
  .state_q      (state_q),
  .mode_q       (mode_q),
  .cfg_se_q     (cfg_se_q),
  .sleep_op     (sleep_op),
  .warm_rst     (warm_rst),
  .wk_level     (wk_level),
  .wk_wdt       (wk_wdt),
  .wk_pin       (wk_pin),
  .clk_cpu_en   (clk_cpu_en),
  .clk_flash_en (clk_flash_en),
  .clk_io_en    (clk_io_en),
  .clk_adc_en   (clk_adc_en),
  .clk_osc_en   (clk_osc_en),
  .cpu_stall    (cpu_stall),
  .take_irq     (take_irq),
  .restart_vec  (restart_vec)
);

// File: tb/test_slpwk_ctrl.sv
`timescale 1ns/1ps
module test_slpwk_ctrl;

  localparam int DLY_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_wr, cfg_se, sleep_op, warm_rst;
  logic [1:0]       cfg_mode;
  logic [DLY_W-1:0] pd_startup;
  logic             wk_level, wk_wdt, wk_pin, wk_timer, wk_adc;
  logic             clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_osc_en;
  logic             cpu_stall, take_irq, restart_vec;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  slpwk_ctrl #(.DLY_W(DLY_W)) i_slpwk_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_se(cfg_se), .cfg_mode(cfg_mode),
    .sleep_op(sleep_op), .pd_startup(pd_startup), .wk_level(wk_level), .wk_wdt(wk_wdt),
    .wk_pin(wk_pin), .wk_timer(wk_timer), .wk_adc(wk_adc), .warm_rst(warm_rst),
    .clk_cpu_en(clk_cpu_en), .clk_flash_en(clk_flash_en), .clk_io_en(clk_io_en),
    .clk_adc_en(clk_adc_en), .clk_osc_en(clk_osc_en), .cpu_stall(cpu_stall),
    .take_irq(take_irq), .restart_vec(restart_vec)
  );

  function automatic logic [4:0] gates();
    return {clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_osc_en};
  endfunction

  function automatic logic [4:0] exp_sleep_gate(int md);
    case (md)
      0:       return 5'b00111;
      1:       return 5'b00011;
      2:       return 5'b00000;
      default: return 5'b00001;
    endcase
  endfunction

  function automatic int exp_startup(int md, int d);
    if (md < 2) return 0;
    if (md == 3) return 6;
    return (d == 0) ? 1 : d;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic set_src(int idx, logic v);
    case (idx)
      0: wk_level = v;
      1: wk_wdt   = v;
      2: wk_pin   = v;
      3: wk_timer = v;
      default: wk_adc = v;
    endcase
  endtask

  task automatic enter_sleep(int md, bit se);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_se = se; cfg_mode = md[1:0];
    @(negedge clk);
    cfg_wr = 1'b0; sleep_op = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    sleep_op = 1'b0;
  endtask

  // sleep in mode md, wake with source src, check latency and pulse
  task automatic sleep_and_wake(int md, int src, int d);
    int st, lat;
    pd_startup = d[DLY_W-1:0];
    enter_sleep(md, 1'b1);
    chk(gates() == exp_sleep_gate(md), "R3", "sleep gates", gates(), exp_sleep_gate(md));
    chk(cpu_stall == 1'b1, "R3", "stall in sleep", cpu_stall, 1);
    st  = exp_startup(md, d);
    lat = 0;
    set_src(src, 1'b1);
    for (int n = 1; n <= 300; n++) begin
      @(posedge clk); #1;
      if (n == 1)
        chk(gates() == ((st > 0) ? 5'b00001 : 5'b11111), "R5", "first wake gates",
            gates(), (st > 0) ? 5'b00001 : 5'b11111);
      if (n == st + 1)
        chk(cpu_stall && gates() == 5'b11111, "R5", "halt stall/gates",
            {cpu_stall, gates()}, 6'b111111);
      if (take_irq) begin
        lat = n;
        break;
      end
    end
    chk(lat == st + 5, "R5", $sformatf("latency md=%0d src=%0d d=%0d", md, src, d), lat, st + 5);
    chk(cpu_stall == 1'b0, "R6", "stall with take", cpu_stall, 0);
    @(negedge clk);
    set_src(src, 1'b0);
    @(posedge clk); #1;
    chk(!take_irq && !cpu_stall && gates() == 5'b11111, "R6", "active after take",
        {take_irq, cpu_stall, gates()}, 7'b0011111);
  endtask

  task automatic pulse_warm();
    @(negedge clk);
    warm_rst = 1'b1;
    @(posedge clk); #1;
    chk(restart_vec && !cpu_stall && !take_irq && gates() == 5'b11111, "R8", "warm restart",
        {restart_vec, cpu_stall, take_irq, gates()}, 8'b10011111);
    @(negedge clk);
    warm_rst = 1'b0;
    @(posedge clk); #1;
    chk(restart_vec == 1'b0, "R8", "restart one cycle", restart_vec, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_wr = 0; cfg_se = 0; cfg_mode = 0; sleep_op = 0; warm_rst = 0;
    pd_startup = 8'd10; wk_level = 0; wk_wdt = 0; wk_pin = 0; wk_timer = 0; wk_adc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;

    // R1 reset state
    chk(gates() == 5'b11111, "R1", "reset gates", gates(), 5'b11111);
    chk(!cpu_stall && !take_irq && !restart_vec, "R1", "reset outputs",
        {cpu_stall, take_irq, restart_vec}, 0);
    // R1: register cleared -> strobe without write does nothing
    @(negedge clk); sleep_op = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); sleep_op = 1'b0;
    chk(!cpu_stall, "R1", "enable bit clear after reset", cpu_stall, 0);

    // R2 no-op with enable clear
    enter_sleep(2, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk(!cpu_stall && gates() == 5'b11111, "R2", "noop stays active",
          {cpu_stall, gates()}, 6'b011111);
    end

    // directed: each mode with an allowed source
    sleep_and_wake(0, 3, 0);
    sleep_and_wake(1, 4, 0);
    sleep_and_wake(2, 1, 10);
    sleep_and_wake(2, 2, 0);
    sleep_and_wake(3, 0, 0);

    // R4 timer/adc ignored in deep modes
    for (int md = 2; md <= 3; md++) begin
      enter_sleep(md, 1'b1);
      @(negedge clk); wk_timer = 1'b1; wk_adc = 1'b1;
      for (int k = 0; k < 30; k++) begin
        @(posedge clk); #1;
        if (k % 10 == 9)
          chk(cpu_stall && !take_irq && gates() == exp_sleep_gate(md), "R4",
              "deep mode ignores timer/adc", {cpu_stall, take_irq, gates()},
              {2'b10, exp_sleep_gate(md)});
      end
      @(negedge clk); wk_timer = 1'b0; wk_adc = 1'b0;
      pulse_warm();
    end

    // R7 short level pulse in power-down: back to sleep
    pd_startup = 8'd10;
    enter_sleep(2, 1'b1);
    @(negedge clk); wk_level = 1'b1;
    @(negedge clk); wk_level = 1'b0;
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 25; k++) begin
        @(posedge clk); #1;
        if (take_irq) seen = 1'b1;
      end
      chk(!seen, "R7", "no take after dropped level", seen, 0);
      chk(cpu_stall && gates() == 5'b00000, "R7", "back asleep",
          {cpu_stall, gates()}, 6'b100000);
    end
    pulse_warm();
    // R7 held level accepted (standby)
    sleep_and_wake(3, 0, 0);

    // R8 warm reset during start-up
    pd_startup = 8'd20;
    enter_sleep(2, 1'b1);
    @(negedge clk); wk_wdt = 1'b1;
    repeat (3) @(posedge clk);
    pulse_warm();
    @(negedge clk); wk_wdt = 1'b0;
    repeat (8) begin
      @(posedge clk); #1;
      chk(!take_irq && !cpu_stall, "R8", "no take after restart", {take_irq, cpu_stall}, 0);
    end

    // random mix
    for (int it = 0; it < 40; it++) begin
      int md, src, d;
      md  = $urandom_range(0, 3);
      src = (md < 2) ? $urandom_range(0, 4) : $urandom_range(0, 2);
      d   = $urandom_range(0, 25);
      sleep_and_wake(md, src, d);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule